// File: doc/BRIEF.md
# SPI Digital Potentiometer Controller

This block is an SPI slave that drives four 8-bit wiper positions. Each wiper has a bank of four data registers that stand in for nonvolatile storage. A host selects a wiper and a register through the instruction byte. It can then read or write a wiper directly, read or write a data register, copy between a register and its wiper for one pot or all four at once, read a status bit, or enter a stepping mode. In stepping mode every further SCK pulse nudges the chosen wiper up or down by one position.

The SPI pins are sampled by the fast system clock, so the bus runs in SPI mode 0 with MSB first. The slave takes SI on the rising SCK edge and updates SO after the falling edge. Any write into a data register models a nonvolatile commit. The commit happens only when chip select is released after a frame of exactly the right length. It starts a busy window of a fixed number of clock cycles. During that window the busy flag reads as set and further nonvolatile writes are refused.

Top module: `pot_spi_ctrl`

## Requirements
- R1: After reset all four wipers and all data registers hold 0, `nv_busy` is 0 and `spi_miso` is 0.
- R2: The instruction byte is the first 8 bits after CS falls, sent MSB first. Bits 7:4 are the opcode, bits 3:2 select the data register and bits 1:0 select the pot. SI is sampled on the rising edge of SCK and SO changes after the falling edge.
- R3: Opcode 1010 followed by an 8-bit data byte loads the selected wiper as soon as the 16th bit is received.
- R4: Opcode 1001 returns the selected wiper and opcode 1011 returns the selected data register, MSB first, on SO during the second byte. SO is 0 outside read data.
- R5: Opcode 1100 followed by a data byte writes the selected data register on the CS rising edge, and only if exactly 16 bits were clocked. A frame cut short commits nothing and does not set busy.
- R6: Every accepted nonvolatile write holds `nv_busy` high for exactly NV_CYCLES clock cycles. Opcode 0101 returns the byte 0000000b, where b is the busy bit.
- R7: A data register write or a store that completes while `nv_busy` is high is ignored, and the busy window is not restarted.
- R8: Opcode 1101 copies data register [reg] of the selected pot into its wiper when the 8th bit is received. Opcode 0001 does the same for all four pots with the one register index.
- R9: Opcode 1110 copies the selected wiper into its data register [reg] on the CS rising edge after exactly 8 bits. Opcode 0011 does this for all four pots. Both start the busy window.
- R10: After opcode 0010, each further rising SCK edge before CS rises moves the selected wiper up by one if SI is 1 and down by one if SI is 0.
- R11: Stepping saturates at 255 and at 0 and never wraps.
- R12: Opcodes not listed above change no wiper, no register and no busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| wiper | output | 4*DW | Wiper positions, pot 0 in the low byte |
| nv_busy | output | 1 | Nonvolatile write in progress |

## Verification
The wipers are loaded with distinct values per pot (A5, 3C, ...) so that a wrong pot select or a wrong register index shows up as a wrong byte. Single-pot and all-pot transfers are run back to back to separate local decoding from global decoding. Stepping runs across both saturation limits and reverses direction. This tells a clamped counter apart from one that wraps, and SI sampled on the right edge apart from a stale bit. Nonvolatile writes are issued while the busy window is still open and also as truncated frames. The busy window's width is measured on every pulse, so an accepted commit, a refused one and a restarted timer each give a different result.

// File: rtl/pot_pkg.sv
package pot_pkg;
  localparam int NPOT = 4;
  localparam int NREG = 4;
  localparam int IB   = 8;
  localparam int PSW  = $clog2(NPOT);
  localparam int RSW  = $clog2(NREG);

  typedef enum logic [3:0] {
    OP_NONE      = 4'b0000,
    OP_LOAD_ALL  = 4'b0001,
    OP_STEP      = 4'b0010,
    OP_STORE_ALL = 4'b0011,
    OP_STATUS    = 4'b0101,
    OP_RD_WCR    = 4'b1001,
    OP_WR_WCR    = 4'b1010,
    OP_RD_DR     = 4'b1011,
    OP_WR_DR     = 4'b1100,
    OP_LOAD      = 4'b1101,
    OP_STORE     = 4'b1110
  } pot_op_e;
endpackage

// File: rtl/pot_spi_front.sv
module pot_spi_front #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_start,
  output logic cs_end,
  output logic bit_o
);
  logic [SYNC:0]   sck_s;
  logic [SYNC:0]   cs_s;
  logic [SYNC-1:0] mo_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s <= '0;
      cs_s  <= '1;
      mo_s  <= '0;
    end else begin
      sck_s <= {sck_s[SYNC-1:0], sck};
      cs_s  <= {cs_s[SYNC-1:0], cs_n};
      mo_s  <= {mo_s[SYNC-2:0], mosi};
    end
  end

  assign sck_rise = sck_s[SYNC-1] & ~sck_s[SYNC] & ~cs_s[SYNC-1];
  assign sck_fall = ~sck_s[SYNC-1] & sck_s[SYNC] & ~cs_s[SYNC-1];
  assign cs_start = cs_s[SYNC] & ~cs_s[SYNC-1];
  assign cs_end   = ~cs_s[SYNC] & cs_s[SYNC-1];
  assign bit_o    = mo_s[SYNC-1];
endmodule

// File: rtl/pot_nv_timer.sv
module pot_nv_timer #(
  parameter int NV_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int TW = $clog2(NV_CYCLES + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= TW'(NV_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  AST_NV_START_IDLE: assert property (@(posedge clk) disable iff (rst) start |-> !busy); // R7
  AST_NV_SETS: assert property (@(posedge clk) disable iff (rst) start |=> busy); // R6
  AST_NV_CLEARS: assert property (@(posedge clk) disable iff (rst) (busy && cnt == '0 && !start) |=> !busy); // R6
endmodule

// File: rtl/pot_bank.sv
module pot_bank
  import pot_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wcr_we,
  input  logic [DW-1:0]  wdata,
  input  logic           ld_en,
  input  logic           step_en,
  input  logic           step_up,
  input  logic           dr_we,
  input  logic           dr_src_wcr,
  input  logic [RSW-1:0] sel,
  input  logic [RSW-1:0] rd_sel,
  output logic [DW-1:0]  wcr,
  output logic [DW-1:0]  rd_dr
);
  localparam logic [DW-1:0] WMAX = '1;
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      wcr <= '0;
    end else if (wcr_we) begin
      wcr <= wdata;
    end else if (ld_en) begin
      wcr <= mem[sel];
    end else if (step_en) begin
      if (step_up && wcr != WMAX)    wcr <= wcr + 1'b1;
      else if (!step_up && wcr != '0) wcr <= wcr - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (dr_we) begin
      mem[sel] <= dr_src_wcr ? wcr : wdata;
    end
  end

  assign rd_dr = mem[rd_sel];

  AST_WCR_WRITE: assert property (@(posedge clk) disable iff (rst) wcr_we |=> wcr == $past(wdata)); // R3
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst) (step_en && !wcr_we && !ld_en && step_up && wcr != WMAX) |=> wcr == $past(wcr) + 1'b1); // R10
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst) (step_en && !wcr_we && !ld_en && step_up && wcr == WMAX) |=> wcr == WMAX); // R11
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst) (step_en && !wcr_we && !ld_en && !step_up && wcr == '0) |=> wcr == '0); // R11
endmodule

// File: rtl/pot_cmd.sv
module pot_cmd
  import pot_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sck_rise,
  input  logic                     sck_fall,
  input  logic                     cs_start,
  input  logic                     cs_end,
  input  logic                     bit_i,
  input  logic                     wip,
  input  logic [NPOT-1:0][DW-1:0]  rd_wcr,
  input  logic [NPOT-1:0][DW-1:0]  rd_dr,
  output logic [RSW-1:0]           rd_sel,
  output logic [NPOT-1:0]          wcr_we,
  output logic [NPOT-1:0]          ld_en,
  output logic [NPOT-1:0]          step_en,
  output logic                     step_up,
  output logic [NPOT-1:0]          dr_we,
  output logic                     dr_src_wcr,
  output logic [DW-1:0]            wdata,
  output logic [RSW-1:0]           sel,
  output logic                     nv_start,
  output logic                     miso
);
  localparam int SW = (DW > IB) ? DW : IB;
  localparam int CW = $clog2(IB + DW + 2);
  localparam logic [CW-1:0] CNT_MAX  = '1;
  localparam logic [CW-1:0] CNT_INS  = CW'(IB - 1);
  localparam logic [CW-1:0] CNT_DATA = CW'(IB + DW - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(IB + DW);
  localparam logic [CW-1:0] CNT_IB   = CW'(IB);

  logic [SW-1:0]  shreg;
  logic [CW-1:0]  cnt;
  logic [3:0]     op;
  logic [RSW-1:0] rsel;
  logic [PSW-1:0] psel;
  logic [DW-1:0]  tx;
  logic [IB-1:0]  ib;
  logic [DW-1:0]  dbyte;
  logic [PSW-1:0] ib_pot;

  assign ib     = {shreg[IB-2:0], bit_i};
  assign dbyte  = {shreg[DW-2:0], bit_i};
  assign ib_pot = ib[PSW-1:0];
  assign rd_sel = ib[PSW+RSW-1:PSW];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0; cnt <= '0; op <= OP_NONE; rsel <= '0; psel <= '0;
      tx <= '0; miso <= 1'b0; wcr_we <= '0; ld_en <= '0; step_en <= '0;
      step_up <= 1'b0; dr_we <= '0; dr_src_wcr <= 1'b0; wdata <= '0;
      sel <= '0; nv_start <= 1'b0;
    end else begin
      wcr_we   <= '0;
      ld_en    <= '0;
      step_en  <= '0;
      dr_we    <= '0;
      nv_start <= 1'b0;
      if (cs_start) begin
        cnt  <= '0;
        op   <= OP_NONE;
        tx   <= '0;
        miso <= 1'b0;
      end else if (cs_end) begin
        miso <= 1'b0;
        op   <= OP_NONE;
        if (!wip) begin
          if (op == OP_WR_DR && cnt == CNT_FULL) begin
            dr_we[psel] <= 1'b1;
            dr_src_wcr  <= 1'b0;
            wdata       <= shreg[DW-1:0];
            sel         <= rsel;
            nv_start    <= 1'b1;
          end else if (op == OP_STORE && cnt == CNT_IB) begin
            dr_we[psel] <= 1'b1;
            dr_src_wcr  <= 1'b1;
            sel         <= rsel;
            nv_start    <= 1'b1;
          end else if (op == OP_STORE_ALL && cnt == CNT_IB) begin
            dr_we      <= '1;
            dr_src_wcr <= 1'b1;
            sel        <= rsel;
            nv_start   <= 1'b1;
          end
        end
      end else if (sck_rise) begin
        shreg <= {shreg[SW-2:0], bit_i};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (cnt == CNT_INS) begin
          op   <= ib[IB-1:IB-4];
          rsel <= ib[PSW+RSW-1:PSW];
          psel <= ib_pot;
          case (ib[IB-1:IB-4])
            OP_RD_WCR: tx <= rd_wcr[ib_pot];
            OP_RD_DR:  tx <= rd_dr[ib_pot];
            OP_STATUS: tx <= {{(DW-1){1'b0}}, wip};
            OP_LOAD: begin
              ld_en[ib_pot] <= 1'b1;
              sel           <= ib[PSW+RSW-1:PSW];
            end
            OP_LOAD_ALL: begin
              ld_en <= '1;
              sel   <= ib[PSW+RSW-1:PSW];
            end
            default: tx <= '0;
          endcase
        end else if (op == OP_WR_WCR && cnt == CNT_DATA) begin
          wcr_we[psel] <= 1'b1;
          wdata        <= dbyte;
        end else if (op == OP_STEP && cnt >= CNT_IB) begin
          step_en[psel] <= 1'b1;
          step_up       <= bit_i;
        end
      end else if (sck_fall) begin
        miso <= tx[DW-1];
        tx   <= {tx[DW-2:0], 1'b0};
      end
    end
  end

  AST_DR_ON_RELEASE: assert property (@(posedge clk) disable iff (rst) (|dr_we) |-> $past(cs_end)); // R5
  AST_STEP_ON_RISE: assert property (@(posedge clk) disable iff (rst) (|step_en) |-> $past(sck_rise)); // R10
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst) nv_start |-> $past(!wip)); // R7
endmodule

// File: rtl/pot_spi_ctrl.sv
module pot_spi_ctrl
  import pot_pkg::*;
#(
  parameter int DW        = 8,
  parameter int NV_CYCLES = 5000,
  parameter int SYNC      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               spi_sck,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso,
  output logic [NPOT*DW-1:0] wiper,
  output logic               nv_busy
);
  logic sck_rise, sck_fall, cs_start, cs_end, bit_s;
  logic [NPOT-1:0][DW-1:0] wcr_all, rd_dr_all;
  logic [RSW-1:0] rd_sel, sel;
  logic [NPOT-1:0] wcr_we, ld_en, step_en, dr_we;
  logic step_up, dr_src_wcr, nv_start;
  logic [DW-1:0] wdata;

  pot_spi_front #(.SYNC(SYNC)) u_front (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_start(cs_start),
    .cs_end(cs_end), .bit_o(bit_s)
  );

  pot_cmd #(.DW(DW)) u_cmd (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_start(cs_start), .cs_end(cs_end), .bit_i(bit_s), .wip(nv_busy),
    .rd_wcr(wcr_all), .rd_dr(rd_dr_all), .rd_sel(rd_sel), .wcr_we(wcr_we),
    .ld_en(ld_en), .step_en(step_en), .step_up(step_up), .dr_we(dr_we),
    .dr_src_wcr(dr_src_wcr), .wdata(wdata), .sel(sel), .nv_start(nv_start),
    .miso(spi_miso)
  );

  pot_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(nv_start), .busy(nv_busy)
  );

  for (genvar g = 0; g < NPOT; g++) begin : g_pot
    pot_bank #(.DW(DW)) u_bank (
      .clk(clk), .rst(rst), .wcr_we(wcr_we[g]), .wdata(wdata),
      .ld_en(ld_en[g]), .step_en(step_en[g]), .step_up(step_up),
      .dr_we(dr_we[g]), .dr_src_wcr(dr_src_wcr), .sel(sel), .rd_sel(rd_sel),
      .wcr(wcr_all[g]), .rd_dr(rd_dr_all[g])
    );
  end

  assign wiper = wcr_all;
endmodule

// File: tb/test_pot_spi_ctrl.sv
module test_pot_spi_ctrl;
  localparam int NV   = 600;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, nv_busy;
  logic [31:0] wiper;

  int checks = 0, errors = 0, cyc = 0, cyc_end = 0, busy_end = 0, wlen = 0;
  bit done = 0;
  int exp_wcr [4];
  int exp_dr [4][4];

  pot_spi_ctrl #(.DW(8), .NV_CYCLES(NV), .SYNC(2)) i_pot_spi_ctrl (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .wiper(wiper), .nv_busy(nv_busy)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R6: every busy pulse must last exactly NV cycles
  always @(negedge clk) begin
    if (!rst) begin
      if (nv_busy) wlen++;
      else if (wlen != 0) begin
        check("R6 busy length", wlen, NV);
        wlen = 0;
      end
    end
  end

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_lo();
    spi_cs_n = 1'b0; half();
  endtask

  task automatic cs_hi();
    half(); spi_cs_n = 1'b1; cyc_end = cyc; half(); half();
  endtask

  task automatic xbit(input logic b, output logic r);
    spi_mosi = b; half(); r = spi_miso; spi_sck = 1'b1; half(); spi_sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      xbit(t[i], b);
      r[i] = b;
    end
  endtask

  function automatic bit free();
    return cyc_end >= busy_end;
  endfunction

  task automatic cmp_wipers(string tag);
    for (int p = 0; p < 4; p++) check(tag, int'(wiper[p*8 +: 8]), exp_wcr[p]);
  endtask

  task automatic wr_wcr(input int p, input logic [7:0] v);
    logic [7:0] r;
    cs_lo(); xbyte({4'b1010, 2'b00, 2'(p)}, r); xbyte(v, r); cs_hi();
    exp_wcr[p] = v;
  endtask

  task automatic rd(input logic [3:0] op, input int rr, input int p, output logic [7:0] v);
    logic [7:0] r;
    cs_lo(); xbyte({op, 2'(rr), 2'(p)}, r); xbyte(8'h00, v); cs_hi();
  endtask

  task automatic wr_dr(input int p, input int rr, input logic [7:0] v);
    logic [7:0] r;
    cs_lo(); xbyte({4'b1100, 2'(rr), 2'(p)}, r); xbyte(v, r); cs_hi();
    if (free()) begin exp_dr[p][rr] = v; busy_end = cyc_end + NV + 6; end
  endtask

  task automatic store(input int p, input int rr, input bit all);
    logic [7:0] r;
    cs_lo(); xbyte({all ? 4'b0011 : 4'b1110, 2'(rr), 2'(p)}, r); cs_hi();
    if (free()) begin
      for (int q = 0; q < 4; q++) if (all || q == p) exp_dr[q][rr] = exp_wcr[q];
      busy_end = cyc_end + NV + 6;
    end
  endtask

  task automatic load(input int p, input int rr, input bit all);
    logic [7:0] r;
    cs_lo(); xbyte({all ? 4'b0001 : 4'b1101, 2'(rr), 2'(p)}, r); cs_hi();
    for (int q = 0; q < 4; q++) if (all || q == p) exp_wcr[q] = exp_dr[q][rr];
  endtask

  task automatic step(input int p, input logic [15:0] dirs, input int n);
    logic [7:0] r;
    logic b;
    cs_lo(); xbyte({4'b0010, 2'b00, 2'(p)}, r);
    for (int i = 0; i < n; i++) begin
      xbit(dirs[i], b);
      if (dirs[i] && exp_wcr[p] < 255) exp_wcr[p]++;
      else if (!dirs[i] && exp_wcr[p] > 0) exp_wcr[p]--;
      check(dirs[i] ? "R10 R11 step up" : "R10 R11 step down", int'(wiper[p*8 +: 8]), exp_wcr[p]);
    end
    cs_hi();
  endtask

  task automatic wait_nv();
    repeat (NV + 60) @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, r;
    logic b;
    for (int p = 0; p < 4; p++) begin
      exp_wcr[p] = 0;
      for (int q = 0; q < 4; q++) exp_dr[p][q] = 0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    cmp_wipers("R1 reset wipers");
    check("R1 reset busy", nv_busy, 0);
    check("R1 reset miso", spi_miso, 0);
    rd(4'b1011, 3, 2, v); check("R1 reset data reg", v, 0);

    // R2 R3 write wipers with distinct values per pot
    wr_wcr(0, 8'hA5); wr_wcr(3, 8'h3C); wr_wcr(1, 8'h11); wr_wcr(2, 8'h80);
    cmp_wipers("R2 R3 wiper write");
    // R4 read back
    rd(4'b1001, 0, 0, v); check("R4 read wiper 0", v, 8'hA5);
    rd(4'b1001, 0, 3, v); check("R4 read wiper 3", v, 8'h3C);
    check("R4 miso idle", spi_miso, 0);

    // R5 R6 data register write with busy
    wr_dr(1, 2, 8'h5A);
    check("R6 busy after commit", nv_busy, 1);
    rd(4'b0101, 0, 0, v); check("R6 status busy", v, 8'h01);
    wr_dr(1, 2, 8'hFF); // R7 ignored, model keeps 5A
    wait_nv();
    check("R6 busy cleared", nv_busy, 0);
    rd(4'b0101, 0, 0, v); check("R6 status idle", v, 8'h00);
    rd(4'b1011, 2, 1, v); check("R5 R7 data reg value", v, exp_dr[1][2]);

    // R5 partial frame aborted
    cs_lo(); xbyte(8'hC6, r);
    for (int i = 0; i < 4; i++) xbit(1'b1, b);
    cs_hi();
    check("R5 partial no busy", nv_busy, 0);
    rd(4'b1011, 1, 2, v); check("R5 partial no commit", v, 0);

    // R8 local load
    load(1, 2, 1'b0); cmp_wipers("R8 local load");

    // R9 local store
    store(0, 3, 1'b0);
    check("R9 store sets busy", nv_busy, 1);
    store(2, 0, 1'b0); // R7 ignored while busy
    wait_nv();
    rd(4'b1011, 3, 0, v); check("R9 local store", v, 8'hA5);
    rd(4'b1011, 0, 2, v); check("R7 store while busy", v, 0);

    // R9 global store, then R8 global load
    store(0, 1, 1'b1);
    wait_nv();
    for (int p = 0; p < 4; p++) begin
      rd(4'b1011, 1, p, v); check("R9 global store", v, exp_dr[p][1]);
    end
    wr_wcr(0, 8'h01); wr_wcr(1, 8'h02); wr_wcr(2, 8'h03); wr_wcr(3, 8'h04);
    load(0, 1, 1'b1); cmp_wipers("R8 global load");

    // R10 R11 stepping across both limits
    wr_wcr(2, 8'hFD);
    step(2, 16'b0000_0000_0001_1111 | 16'b0, 8);
    wr_wcr(3, 8'h01);
    step(3, 16'b0000_0000_0001_1000, 6);
    cmp_wipers("R10 after stepping");

    // R12 unassigned opcodes
    cs_lo(); xbyte(8'h7F, r); xbyte(8'hFF, r); cs_hi();
    cs_lo(); xbyte(8'hF3, r); cs_hi();
    cs_lo(); xbyte(8'h4A, r); xbyte(8'h00, r); cs_hi();
    cmp_wipers("R12 unknown opcode wipers");
    check("R12 unknown opcode busy", nv_busy, 0);
    rd(4'b1011, 3, 3, v); check("R12 unknown opcode data reg", v, exp_dr[3][3]);

    repeat (20) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule